// File: doc/BRIEF.md
# Masked GPIO Bank Register File

A 32-bit general-purpose I/O bank with a small memory-mapped register interface. Software sets the output level of each pin in one of two ways. A full-word write replaces all 32 output bits. A masked half-word write changes any chosen subset of either the lower or the upper 16 bits in a single store, so no read-modify-write is needed. Per-pin direction and output-enable registers decide which pins are driven. An external per-pin force input can tri-state any pin regardless of those registers.

A read-only register returns the synchronized level on each pin, whether the pin is an input or an output. Reading any of the three output-data registers returns the stored output value and never the pin level. Read data is registered and appears on the edge that takes the read strobe. Register writes take effect on the same edge.

Top module: `gpio_bank_regs`

## Requirements
- R1: After synchronous reset, the output data, direction and enable registers are 0: pin_out is 0, pin_tri is all ones and bus_rdata is 0.
- R2: A write to offset 0x08 loads all 32 bits of bus_wdata into the output data register, and pin_out shows them after that edge.
- R3: A write to offset 0x00 updates output bit i (i in 0..15) with bus_wdata[i] only when bus_wdata[16+i] is 0. If bus_wdata[16+i] is 1, bit i keeps its value. Output bits 31:16 are unchanged.
- R4: A write to offset 0x04 updates output bit 16+i with bus_wdata[i] only when bus_wdata[16+i] is 0. Output bits 15:0 are unchanged.
- R5: A read at offset 0x00, 0x04 or 0x08 returns the current output data register, not the pin levels.
- R6: A read at offset 0x0C returns pin_in after a two-flop synchronizer. A level present before edge k is returned by a read strobed at edge k+2. Writes to 0x0C change nothing.
- R7: Offsets 0x10 (direction) and 0x14 (enable) are read/write. pin_tri[i] is 0 only when direction bit i is 1, enable bit i is 1 and tri_force[i] is 0.
- R8: tri_force[i] = 1 sets pin_tri[i] to 1 in the same cycle, whatever the register contents.
- R9: A read at any other offset, including unaligned ones, returns 0. A write to such an offset changes no register.
- R10: bus_rdata changes only on an edge with bus_re = 1 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin levels (asynchronous) |
| tri_force | input | 32 | Per-pin forced tri-state |
| pin_out | output | 32 | Output value per pin |
| pin_tri | output | 32 | Per-pin tri-state, 1 = not driven |

## Verification
A corrupted output data bit shows on pin_out on the very next edge. It also shows in the next read of any of the three data offsets, so a masked write that touches the wrong half or inverts the mask sense is caught within one cycle of the store. A wrong direction or enable bit shows at once on pin_tri, except on pins that tri_force hides. A synchronizer with the wrong depth shows as a read of 0x0C that is one cycle early or late after a pin change.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_DATA,
    SEL_PINS,
    SEL_DIR,
    SEL_OE,
    SEL_NONE
  } reg_sel_e;

  localparam logic [7:0] OFS_MASK_LO = 8'h00;
  localparam logic [7:0] OFS_MASK_HI = 8'h04;
  localparam logic [7:0] OFS_DATA    = 8'h08;
  localparam logic [7:0] OFS_PINS    = 8'h0C;
  localparam logic [7:0] OFS_DIR     = 8'h10;
  localparam logic [7:0] OFS_OE      = 8'h14;

  function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_MASK_LO: return SEL_MASK_LO;
      OFS_MASK_HI: return SEL_MASK_HI;
      OFS_DATA:    return SEL_DATA;
      OFS_PINS:    return SEL_PINS;
      OFS_DIR:     return SEL_DIR;
      OFS_OE:      return SEL_OE;
      default:     return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] keep_mask;
  logic [HALF_W-1:0] half_val;
  logic [DATA_W-1:0] data_nxt;

  assign keep_mask = wdata[DATA_W-1:HALF_W];
  assign half_val  = wdata[HALF_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic              sel_wr;
    logic [HALF_W-1:0] cur;
    assign sel_wr = (h == 0) ? wr_lo : wr_hi;
    assign cur    = data_q[h*HALF_W +: HALF_W];
    assign data_nxt[h*HALF_W +: HALF_W] =
      wr_full ? wdata[h*HALF_W +: HALF_W] :
      sel_wr  ? ((cur & keep_mask) | (half_val & ~keep_mask)) :
                cur;
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= data_nxt;
  end
endmodule

// File: rtl/gpio_drive_ctl.sv
module gpio_drive_ctl #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_dir,
  input  logic         wr_oe,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] tri_force,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oe_q,
  output logic [W-1:0] pin_tri
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      oe_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_oe)  oe_q  <= wdata;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_tri[i] = tri_force[i] | ~(dir_q[i] & oe_q[i]);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] tri_force,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_tri
);
  import gpio_bank_pkg::*;

  reg_sel_e          sel;
  logic [DATA_W-1:0] data_q, dir_q, oe_q, pins_sync;
  logic [DATA_W-1:0] rd_mux;

  assign sel = decode_ofs(8'(bus_addr));

  gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_in),
    .d_sync  (pins_sync)
  );

  gpio_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .wr_full (bus_we && sel == SEL_DATA),
    .wr_lo   (bus_we && sel == SEL_MASK_LO),
    .wr_hi   (bus_we && sel == SEL_MASK_HI),
    .wdata   (bus_wdata),
    .data_q  (data_q)
  );

  gpio_drive_ctl #(.W(DATA_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .wr_dir    (bus_we && sel == SEL_DIR),
    .wr_oe     (bus_we && sel == SEL_OE),
    .wdata     (bus_wdata),
    .tri_force (tri_force),
    .dir_q     (dir_q),
    .oe_q      (oe_q),
    .pin_tri   (pin_tri)
  );

  always_comb begin
    case (sel)
      SEL_MASK_LO, SEL_MASK_HI, SEL_DATA: rd_mux = data_q;
      SEL_PINS: rd_mux = pins_sync;
      SEL_DIR:  rd_mux = dir_q;
      SEL_OE:   rd_mux = oe_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign pin_out = data_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] tri_force,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_tri
);
  localparam int HALF_W = DATA_W / 2;
  logic unmapped;
  assign unmapped = !(bus_addr inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14});

  AST_RESET_OUT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_out == '0 && bus_rdata == '0));  // R1
  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h08) |=> pin_out == $past(bus_wdata));  // R2
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h00) |=> pin_out[DATA_W-1:HALF_W] == $past(pin_out[DATA_W-1:HALF_W]));  // R3
  AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == 8'h04) |=> pin_out[HALF_W-1:0] == $past(pin_out[HALF_W-1:0]));  // R4
  AST_DIR_OFF_TRI: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == 8'h10 || bus_addr == 8'h14) && bus_wdata == '0) |=> pin_tri == '1);  // R7
  AST_FORCE_TRI: assert property (@(posedge clk) disable iff (rst)
    (pin_tri & tri_force) == tri_force);  // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && unmapped) |=> bus_rdata == '0);  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));  // R10
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tri_force (tri_force),
  .pin_out   (pin_out),
  .pin_tri   (pin_tri)
);

// File: tb/test_gpio_bank_regs.sv
`timescale 1ns/1ps
module test_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, pin_in = '0, tri_force = '0;
  logic [31:0] bus_rdata, pin_out, pin_tri;

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";

  // reference model state
  logic [31:0] m_data, m_dir, m_oe, m_s1, m_s2, m_rd;

  always #10 clk = ~clk;

  gpio_bank_regs i_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .tri_force(tri_force), .pin_out(pin_out), .pin_tri(pin_tri)
  );

  task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h", phase, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_data = '0; m_dir = '0; m_oe = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      if (bus_re) begin
        case (bus_addr)
          8'h00, 8'h04, 8'h08: m_rd = m_data;
          8'h0C: m_rd = m_s2;
          8'h10: m_rd = m_dir;
          8'h14: m_rd = m_oe;
          default: m_rd = '0;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
      if (bus_we) begin
        case (bus_addr)
          8'h00: for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_data[i] = bus_wdata[i];
          8'h04: for (int i = 0; i < 16; i++) if (!bus_wdata[16+i]) m_data[16+i] = bus_wdata[i];
          8'h08: m_data = bus_wdata;
          8'h10: m_dir = bus_wdata;
          8'h14: m_oe = bus_wdata;
          default: ;
        endcase
      end
    end
    #5;
    cmp("pin_out", pin_out, m_data);
    cmp("pin_tri", pin_tri, tri_force | ~(m_dir & m_oe));
    cmp("bus_rdata", bus_rdata, m_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    phase = "R1";
    idle(3); rst = 1'b0; idle(2);
    rd(8'h08); rd(8'h10); rd(8'h14);

    phase = "R2";
    wr(8'h08, 32'hA5A5_5A5A); rd(8'h08);
    wr(8'h08, 32'hFFFF_0000); wr(8'h08, 32'h0000_0000);

    phase = "R3";
    wr(8'h08, 32'h1357_9BDF);
    wr(8'h00, {16'h00FF, 16'h1234});   // bits 15:8 written
    wr(8'h00, {16'hFFFF, 16'hAAAA});   // nothing written
    wr(8'h00, {16'h0000, 16'hC3C3});   // all low bits written
    rd(8'h00);

    phase = "R4";
    wr(8'h04, {16'hF0F0, 16'h5555});
    wr(8'h04, {16'h0000, 16'hBEEF});
    wr(8'h04, {16'hFFFF, 16'h0000});
    rd(8'h04);

    phase = "R5";
    pin_in = 32'h0F0F_F0F0;
    idle(3);
    rd(8'h00); rd(8'h04); rd(8'h08);

    phase = "R6";
    pin_in = 32'hDEAD_BEEF;
    rd(8'h0C);
    @(negedge clk); pin_in = 32'h1234_5678; bus_addr = 8'h0C; bus_re = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk); bus_re = 1'b0;
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h08); rd(8'h0C);

    phase = "R7";
    wr(8'h10, 32'hFFFF_0000); wr(8'h14, 32'h00FF_FF00);
    rd(8'h10); rd(8'h14);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h10, 32'h0000_0000);
    wr(8'h10, 32'hFFFF_FFFF);

    phase = "R8";
    @(negedge clk); tri_force = 32'h8000_0001;
    @(negedge clk); tri_force = 32'hFFFF_FFFF;
    @(negedge clk); tri_force = 32'h0000_FFFF;
    @(negedge clk); tri_force = '0;

    phase = "R9";
    rd(8'h18); rd(8'h1C); rd(8'h02); rd(8'hFF);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h09, 32'h0);
    rd(8'h08); rd(8'h10);

    phase = "R10";
    rd(8'h10);
    idle(5);

    phase = "R3";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      a = 8'(($urandom % 8) * 4);
      @(negedge clk);
      bus_addr = a; bus_wdata = $urandom; pin_in = $urandom;
      tri_force = (k % 5 == 0) ? $urandom : '0;
      bus_we = $urandom % 2; bus_re = $urandom % 2;
    end
    @(negedge clk); bus_we = 1'b0; bus_re = 1'b0;
    idle(3);
    finish_run();
  end
endmodule